// File: doc/BRIEF.md
# Split Dual 8-Bit Reload Timer

This block is a timer that runs as two separate 8-bit up-counters, a low half and a high half. Each half reloads from its own reload register when it wraps past its all-ones value. Each half takes its count enable from a tick source picked by its own speed-select bit: every system clock cycle, the system clock divided by 12, or an external enable input divided by 8. The external input is a synchronized enable: each cycle it is high counts as one external clock edge.

Software reaches the block through a small register port with a write strobe and a read strobe. The port gives access to a control register, the two counters and the two reload registers. Run control is asymmetric. The run bit gates only the high half, and the low half counts on every selected tick. Each half has a sticky overflow flag. Both flags feed one level-sensitive interrupt request. The low flag contributes to that request only when its own enable bit is set.

Top module: `dual_reload_timer`

## Requirements
- R1: When the low counter counts from 0xFF it loads the low reload register instead of going to 0x00.
- R2: When the high counter counts from 0xFF it loads the high reload register instead of going to 0x00.
- R3: The run bit (control bit 0) gates only the high counter. The low counter advances on every selected tick whether the run bit is 0 or 1.
- R4: A half whose fast bit is 1 (control bit 5 for the low half, bit 4 for the high half) advances on every clock cycle, and the external-select bit (control bit 3) has no effect on it.
- R5: A half whose fast bit is 0 advances once per 12 clock cycles when the external-select bit is 0.
- R6: A half whose fast bit is 0 advances once per 8 cycles in which `ext_tick` is high when the external-select bit is 1. Both halves share this divided tick.
- R7: A wrap of the high counter sets the high flag (control bit 7). A wrap of the low counter sets the low flag (control bit 6).
- R8: `irq` is high exactly while the interrupt enable (control bit 2) is 1 and either the high flag is 1 or both the low flag and the low-interrupt enable (control bit 1) are 1.
- R9: The flags are never cleared by hardware. A control write loads both flag bits from the written data, so writing 0 clears a flag.
- R10: If a control write that clears a flag lands in the same cycle as an overflow of that flag's half, the flag ends up set.
- R11: A write to a counter takes priority over counting and reloading in that cycle, and no overflow is recorded for that cycle.
- R12: After reset the control register, both counters and both reload registers read 0, and `irq` is 0.
- R13: Register addresses are 0 control, 1 low counter, 2 high counter, 3 low reload, 4 high reload. `rd_data` shows the addressed register while `rd_en` is high and shows 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_tick | input | 1 | Synchronized external clock enable, one edge per high cycle |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The bench builds the block with its default parameters: 8-bit counters, a divide-by-12 system prescaler and a divide-by-8 external prescaler. With 8-bit counters, wraps and reloads happen within a few hundred cycles, so every reload and flag path can be reached in a short run. The divide windows are checked over exact multiples of the divide ratio (120 cycles, 80 external pulses), so the expected counts do not depend on the phase of the free-running prescalers.

// File: rtl/drt_pkg.sv
// Package: shared constants and types for the split dual reload timer.
// Assumes an 8-bit register data path; the control register layout below
// is fixed and decoded by the top module.
package drt_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_LO_CNT = 3'd1,
        A_HI_CNT = 3'd2,
        A_LO_RLD = 3'd3,
        A_HI_RLD = 3'd4
    } reg_addr_e;

    // Control register, bit 7 down to bit 0.
    typedef struct packed {
        logic hi_flag;
        logic lo_flag;
        logic lo_fast;
        logic hi_fast;
        logic ext_sel;
        logic irq_en;
        logic lo_irq_en;
        logic hi_run;
    } ctrl_t;

endpackage

// File: rtl/drt_prescaler.sv
// Module: drt_prescaler
// Free-running divider. Counts cycles in which en is high and emits a
// one-cycle tick on every DIV-th such cycle. Assumes en is synchronous to clk.
module drt_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    // Advance the divide counter on each enabled cycle, wrapping at DIV.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (en)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_chk
            // R5 / R6: a divided tick never lasts two cycles in a row
            p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/drt_half.sv
// Module: drt_half
// One 8-bit half of the timer: counts on tick when run is high, reloads on
// wrap from all-ones, and reports the wrap on ovf. A software write to the
// counter wins over counting and suppresses the overflow of that cycle.
module drt_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         wr_cnt,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] rld,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    logic [W-1:0] cnt_q;
    logic         step;

    assign step = tick & run;
    assign ovf  = step & ~wr_cnt & (&cnt_q);
    assign cnt  = cnt_q;

    // Counter update: software write first, then reload on wrap, then count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr_cnt)
            cnt_q <= wr_data;
        else if (ovf)
            cnt_q <= rld;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    // R1 / R2: a wrap loads the reload value seen at that edge
    p_wrap_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt_q == $past(rld)));

    // R11: a counter write takes the written value
    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_q == $past(wr_data)));

    // R3: without an enabled tick and without a write, the count holds
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_cnt) |=> $stable(cnt_q));

endmodule

// File: rtl/dual_reload_timer.sv
// Module: dual_reload_timer
// Two independent 8-bit reload counters with per-half tick selection,
// sticky overflow flags and one level interrupt. Assumes ext_tick is
// already synchronized to clk. Index 0 is the low half, index 1 the high half.
module dual_reload_timer
    import drt_pkg::*;
#(
    parameter int SYS_DIV = 12,
    parameter int EXT_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int NHALF = 2;

    ctrl_t                   ctrl_q;
    logic                    sys_div_tick;
    logic                    ext_div_tick;
    logic                    slow_tick;
    logic                    wr_ctrl;
    logic [NHALF-1:0]        fast;
    logic [NHALF-1:0]        run;
    logic [NHALF-1:0]        tick;
    logic [NHALF-1:0]        wr_cnt;
    logic [NHALF-1:0]        wr_rld;
    logic [NHALF-1:0]        ovf;
    logic [DATA_W-1:0]       cnt   [NHALF];
    logic [DATA_W-1:0]       rld_q [NHALF];

    drt_prescaler #(.DIV(SYS_DIV)) u_sys_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (1'b1),
        .tick  (sys_div_tick)
    );

    drt_prescaler #(.DIV(EXT_DIV)) u_ext_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ext_tick),
        .tick  (ext_div_tick)
    );

    assign slow_tick = ctrl_q.ext_sel ? ext_div_tick : sys_div_tick;
    assign wr_ctrl   = wr_en && (addr == A_CTRL);

    assign fast[0]   = ctrl_q.lo_fast;
    assign fast[1]   = ctrl_q.hi_fast;
    assign run[0]    = 1'b1;
    assign run[1]    = ctrl_q.hi_run;
    assign wr_cnt[0] = wr_en && (addr == A_LO_CNT);
    assign wr_cnt[1] = wr_en && (addr == A_HI_CNT);
    assign wr_rld[0] = wr_en && (addr == A_LO_RLD);
    assign wr_rld[1] = wr_en && (addr == A_HI_RLD);

    generate
        for (genvar i = 0; i < NHALF; i++) begin : g_half
            assign tick[i] = fast[i] ? 1'b1 : slow_tick;

            // Reload register of this half, written by software only.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rld_q[i] <= '0;
                else if (wr_rld[i])
                    rld_q[i] <= wr_data;
            end

            drt_half #(.W(DATA_W)) u_half (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick[i]),
                .run     (run[i]),
                .wr_cnt  (wr_cnt[i]),
                .wr_data (wr_data),
                .rld     (rld_q[i]),
                .cnt     (cnt[i]),
                .ovf     (ovf[i])
            );
        end
    endgenerate

    // Control register: software write, then overflow sets flags (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(wr_data);
            if (ovf[0])
                ctrl_q.lo_flag <= 1'b1;
            if (ovf[1])
                ctrl_q.hi_flag <= 1'b1;
        end
    end

    assign irq = ctrl_q.irq_en &
                 (ctrl_q.hi_flag | (ctrl_q.lo_irq_en & ctrl_q.lo_flag));

    // Read multiplexer, forced to zero when no read is strobed.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (addr)
                A_CTRL:   rd_data = ctrl_q;
                A_LO_CNT: rd_data = cnt[0];
                A_HI_CNT: rd_data = cnt[1];
                A_LO_RLD: rd_data = rld_q[0];
                A_HI_RLD: rd_data = rld_q[1];
                default:  rd_data = '0;
            endcase
        end
    end

    // R7 / R10: an overflow always leaves its flag set, even against a clear
    p_hi_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf[1] |=> ctrl_q.hi_flag);
    p_lo_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf[0] |=> ctrl_q.lo_flag);

    // R9: without a control write a set flag stays set
    p_hi_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.hi_flag && !wr_ctrl) |=> ctrl_q.hi_flag);
    p_lo_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.lo_flag && !wr_ctrl) |=> ctrl_q.lo_flag);

    // R3: a stopped high half with no write keeps its count
    p_run_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.hi_run && !wr_cnt[1]) |=> $stable(cnt[1]));

    // R8: a raised request always has a set flag behind it
    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl_q.hi_flag || ctrl_q.lo_flag));

endmodule

// File: tb/sim_dual_reload_timer.sv
module sim_dual_reload_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;

    // {ctrl, low reload, low start, cycles, expected low count}
    localparam logic [39:0] VEC [NVEC] = '{
        {8'h20, 8'h00, 8'h10, 8'd5,   8'h15},  // R4 fast low, plain count
        {8'h20, 8'h40, 8'hFE, 8'd3,   8'h41},  // R1 wrap loads reload
        {8'h20, 8'hFF, 8'hFF, 8'd3,   8'hFF},  // R1 reload of all-ones
        {8'h21, 8'h00, 8'h00, 8'd200, 8'hC8},  // R3 low counts with run set
        {8'h00, 8'h00, 8'h00, 8'd120, 8'h0A},  // R5 divide by 12
        {8'h08, 8'h00, 8'h33, 8'd50,  8'h33},  // R6 no ext pulses, no count
        {8'h28, 8'h00, 8'h00, 8'd9,   8'h09}   // R4 fast ignores ext select
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_tick = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    dual_reload_timer u0 (
        .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // Called just after a negedge; returns just after the next negedge.
    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        rd_en = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        for (int a = 0; a < 5; a++) begin
            do_read(3'(a), v);
            check("R12 reset register", v, 8'h00);
        end
        check("R12 reset irq", {7'd0, irq}, 8'h00);

        // Vector table on the low half
        for (int i = 0; i < NVEC; i++) begin
            do_write(3'd0, VEC[i][39:32]);
            do_write(3'd3, VEC[i][31:24]);
            do_write(3'd1, VEC[i][23:16]);
            repeat (int'(VEC[i][15:8])) @(negedge clk);
            do_read(3'd1, v);
            check($sformatf("R1/R3/R4/R5/R6 vector %0d", i), v, VEC[i][7:0]);
        end

        // R13 readback of a reload register and read strobe gating
        do_write(3'd4, 8'h5A);
        do_read(3'd4, v);
        check("R13 high reload readback", v, 8'h5A);
        addr = 3'd4; #1;
        check("R13 read data zero without strobe", rd_data, 8'h00);

        // R3 high half gated by run
        do_write(3'd0, 8'h10);
        do_write(3'd2, 8'h05);
        repeat (10) @(negedge clk);
        do_read(3'd2, v);
        check("R3 high held while stopped", v, 8'h05);
        do_write(3'd0, 8'h11);
        repeat (10) @(negedge clk);
        do_read(3'd2, v);
        check("R3 high counts while running", v, 8'h0F);

        // R2 / R7 / R8 high wrap, flag and interrupt
        do_write(3'd0, 8'h15);
        do_write(3'd4, 8'hA0);
        do_write(3'd2, 8'hFE);
        repeat (2) @(negedge clk);
        do_read(3'd2, v);
        check("R2 high wrap loads reload", v, 8'hA0);
        do_read(3'd0, v);
        check("R7 high flag set", v & 8'h80, 8'h80);
        check("R8 irq on high flag", {7'd0, irq}, 8'h01);

        // R9 sticky, then cleared by software
        repeat (50) @(negedge clk);
        do_read(3'd0, v);
        check("R9 high flag still set", v & 8'h80, 8'h80);
        do_write(3'd0, 8'h14);
        do_read(3'd0, v);
        check("R9 high flag cleared by write", v & 8'h80, 8'h00);
        check("R9 irq drops after clear", {7'd0, irq}, 8'h00);

        // R7 / R8 low flag and its enable
        do_write(3'd0, 8'h24);
        do_write(3'd1, 8'hFF);
        @(negedge clk);
        do_read(3'd0, v);
        check("R7 low flag set", v & 8'h40, 8'h40);
        check("R8 low flag without low enable", {7'd0, irq}, 8'h00);
        do_write(3'd0, 8'h66);
        check("R8 low flag with low enable", {7'd0, irq}, 8'h01);
        do_write(3'd0, 8'h62);
        check("R8 interrupt enable off", {7'd0, irq}, 8'h00);

        // R10 set wins over a clear in the same cycle
        do_write(3'd0, 8'h20);
        do_write(3'd1, 8'hFE);
        @(negedge clk);
        do_write(3'd0, 8'h20);
        do_read(3'd0, v);
        check("R10 set wins over clear", v & 8'h40, 8'h40);

        // R11 counter write beats the wrap
        do_write(3'd0, 8'h20);
        do_write(3'd1, 8'hFF);
        do_write(3'd1, 8'h55);
        do_read(3'd1, v);
        check("R11 write beats wrap", v, 8'h55);
        do_read(3'd0, v);
        check("R11 no flag from suppressed wrap", v & 8'h40, 8'h00);

        // R6 external divide by 8, shared by both halves
        do_write(3'd0, 8'h09);
        do_write(3'd1, 8'h00);
        do_write(3'd2, 8'h00);
        for (int p = 0; p < 80; p++) begin
            ext_tick = 1'b1;
            @(negedge clk);
            ext_tick = 1'b0;
            @(negedge clk);
        end
        do_read(3'd1, v);
        check("R6 low external divide", v, 8'h0A);
        do_read(3'd2, v);
        check("R6 high external divide", v, 8'h0A);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule